// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running calendar, supplied as seven BCD fields (seconds, minutes, hours, weekday, day of month, month, year), and raises an alarm when it reaches a programmed moment. Every alarm field has its own compare enable. Only enabled fields take part in the match, so software can ignore fields such as the weekday, or build a daily or hourly alarm by leaving the higher fields out.

Software writes alarm values into staging registers through a simple write port. A separate commit register moves all staged fields into the active compare set in one step, so the comparator never sees a half-written alarm. When a new match begins, a sticky status bit is set. Software clears it by writing a one. The interrupt output is the status bit gated by an interrupt-enable bit. The calendar counter is outside this block and drives it through input ports.

Top module: `cal_alarm_match`

## Requirements
- R1: Writing the alarm field registers (addresses 0 to 6: seconds, minutes, hours, weekday, day, month, year) changes only the staging copy. Until a commit, the match uses the previously committed values.
- R2: A write to address 7 with bit 15 set copies all seven staged fields, values and enables, into the active set in that cycle. A write to address 7 with bit 15 clear has no effect.
- R3: Bit 15 of a field register is that field's compare enable. A field whose enable is clear does not affect the match, whatever its value.
- R4: When no field enable is set in the active set, the alarm never fires.
- R5: The status bit is set at the clock edge that ends the first cycle in which every enabled field equals the calendar. It then stays set, even after the calendar moves on, until it is cleared.
- R6: After the status is cleared, it is not set again while the match condition holds. The condition must go false and then become true again.
- R7: Writing address 9 with bit 0 set clears the status. A write there with bit 0 clear leaves it unchanged.
- R8: The interrupt output is high exactly when the status bit is set and bit 0 of the interrupt-enable register (address 8) is set. Other bits of that register have no effect.
- R9: If a new match begins in the same cycle as a status clear write, the status ends up set.
- R10: After reset the status, the interrupt, the interrupt enable and all active field enables are zero.
- R11: Only the low bits of each field value take part: 7 bits for seconds and minutes, 6 for hours, 3 for weekday, 6 for day, 5 for month and 8 for year. Bits written above a field's width are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0..6 fields, 7 commit, 8 interrupt enable, 9 status |
| wr_data | input | 16 | Write data |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_wday | input | 3 | Calendar weekday |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_month | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year, BCD |
| alarm_status | output | 1 | Sticky alarm status |
| alarm_irq | output | 1 | Interrupt, status gated by enable |

## Verification
Two functions can land in the same cycle: the hardware setting the status on a new match, and software clearing it through the write port. The bench first sets the status, then moves the calendar away so the match drops. On a single falling edge it restores the calendar and drives the clear write, so both reach the same rising edge. The expected result is a set status one cycle later. A clear made while the match is held, with no new match starting, must leave the status clear.

// File: rtl/cam_pkg.sv
package cam_pkg;
   localparam int NUM_FIELDS  = 7;
   localparam int FIELD_MAX_W = 8;

   localparam int ADDR_COMMIT = 7;
   localparam int ADDR_IRQ_EN = 8;
   localparam int ADDR_STATUS = 9;

   typedef logic [FIELD_MAX_W-1:0] fval_t;

   // BCD width of each calendar field, by field index
   function automatic int field_width(input int idx);
      case (idx)
         0:       return 7;   // seconds
         1:       return 7;   // minutes
         2:       return 6;   // hours
         3:       return 3;   // weekday
         4:       return 6;   // day of month
         5:       return 5;   // month
         default: return 8;   // year
      endcase
   endfunction
endpackage

// File: rtl/cam_stage_regs.sv
module cam_stage_regs
   import cam_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int EN_POS  = 15,
   parameter int CMT_POS = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   output fval_t [NUM_FIELDS-1:0]       act_val,
   output logic  [NUM_FIELDS-1:0]       act_en
);

   logic commit;
   logic unused_data;

   assign commit      = wr_en && (wr_addr == ADDR_W'(ADDR_COMMIT)) && wr_data[CMT_POS];
   assign unused_data = ^wr_data;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      localparam int W = field_width(i);

      fval_t stg_val;
      logic  stg_en;
      logic  sel;

      assign sel = wr_en && (wr_addr == ADDR_W'(i));

      // staging copy: written by software, invisible to the compare
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_val <= '0;
            stg_en  <= 1'b0;
         end else if (sel) begin
            stg_val <= fval_t'(wr_data[W-1:0]);
            stg_en  <= wr_data[EN_POS];
         end
      end

      // active copy: loaded from staging for all fields at once
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_val[i] <= '0;
            act_en[i]  <= 1'b0;
         end else if (commit) begin
            act_val[i] <= stg_val;
            act_en[i]  <= stg_en;
         end
      end
   end

endmodule

// File: rtl/cam_field_cmp.sv
module cam_field_cmp
   import cam_pkg::*;
#(
   parameter int W = 8
) (
   input  fval_t alarm,
   input  fval_t cal,
   input  logic  en,
   output logic  hit
);

   localparam fval_t MASK = fval_t'((1 << W) - 1);

   if (W < 1 || W > FIELD_MAX_W) begin : g_bad_width
      $error("cam_field_cmp: field width out of range");
   end

   fval_t diff;

   assign diff = (alarm ^ cal) & MASK;
   // a disabled field always reports a hit so it drops out of the AND
   assign hit  = !en || (diff == '0);

endmodule

// File: rtl/cam_status_irq.sv
module cam_status_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic match_now,
   input  logic clr_req,
   input  logic ie_wr,
   input  logic ie_din,
   output logic status,
   output logic irq_en,
   output logic irq
);

   logic match_q;
   logic rise;

   assign rise = match_now && !match_q;

   always_ff @(posedge clk) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match_now;
   end

   // a hardware set takes priority over a software clear
   always_ff @(posedge clk) begin
      if (!rst_n)       status <= 1'b0;
      else if (rise)    status <= 1'b1;
      else if (clr_req) status <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     irq_en <= 1'b0;
      else if (ie_wr) irq_en <= ie_din;
   end

   assign irq = status && irq_en;

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
   import cam_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int EN_POS  = 15,
   parameter int CMT_POS = 15,
   parameter int IE_POS  = 0,
   parameter int ST_POS  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [6:0]        cal_sec,
   input  logic [6:0]        cal_min,
   input  logic [5:0]        cal_hour,
   input  logic [2:0]        cal_wday,
   input  logic [5:0]        cal_day,
   input  logic [4:0]        cal_month,
   input  logic [7:0]        cal_year,
   output logic              alarm_status,
   output logic              alarm_irq
);

   if (EN_POS >= DATA_W || EN_POS < FIELD_MAX_W) begin : g_bad_en
      $error("cal_alarm_match: enable bit must sit above the field value and inside the word");
   end
   if (CMT_POS >= DATA_W || IE_POS >= DATA_W || ST_POS >= DATA_W) begin : g_bad_pos
      $error("cal_alarm_match: control bit position outside the data word");
   end
   if ((1 << ADDR_W) <= ADDR_STATUS) begin : g_bad_addr
      $error("cal_alarm_match: address width too small for the register set");
   end

   fval_t [NUM_FIELDS-1:0] act_val;
   logic  [NUM_FIELDS-1:0] field_en;
   fval_t [NUM_FIELDS-1:0] cal_f;
   logic  [NUM_FIELDS-1:0] hit;
   logic                   match_now;
   logic                   clr_req;
   logic                   ie_wr;
   logic                   irq_en;

   assign cal_f[0] = fval_t'(cal_sec);
   assign cal_f[1] = fval_t'(cal_min);
   assign cal_f[2] = fval_t'(cal_hour);
   assign cal_f[3] = fval_t'(cal_wday);
   assign cal_f[4] = fval_t'(cal_day);
   assign cal_f[5] = fval_t'(cal_month);
   assign cal_f[6] = fval_t'(cal_year);

   cam_stage_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .EN_POS (EN_POS),
      .CMT_POS(CMT_POS)
   ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .act_val(act_val),
      .act_en (field_en)
   );

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
      cam_field_cmp #(.W(field_width(i))) u_cmp (
         .alarm(act_val[i]),
         .cal  (cal_f[i]),
         .en   (field_en[i]),
         .hit  (hit[i])
      );
   end

   // with no field enabled the AND of hits is vacuous, so require at least one
   assign match_now = (|field_en) && (&hit);

   assign clr_req = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS)) && wr_data[ST_POS];
   assign ie_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_IRQ_EN));

   cam_status_irq u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .match_now(match_now),
      .clr_req  (clr_req),
      .ie_wr    (ie_wr),
      .ie_din   (wr_data[IE_POS]),
      .status   (alarm_status),
      .irq_en   (irq_en),
      .irq      (alarm_irq)
   );

endmodule

// File: rtl/cam_alarm_chk.sv
module cam_alarm_chk
   import cam_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter int IE_POS = 0,
   parameter int ST_POS = 0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [ADDR_W-1:0]     wr_addr,
   input logic [DATA_W-1:0]     wr_data,
   input logic [NUM_FIELDS-1:0] field_en,
   input logic                  match_now,
   input logic                  status,
   input logic                  irq
);

   logic clr_w;
   logic ie_off_w;

   assign clr_w    = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS)) && wr_data[ST_POS];
   assign ie_off_w = wr_en && (wr_addr == ADDR_W'(ADDR_IRQ_EN)) && !wr_data[IE_POS];

   // R4: nothing enabled means no match
   a_r4_no_enable_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (field_en == '0) |-> !match_now);

   // R5: the start of a match sets the status
   a_r5_set_on_new_match: assert property (@(posedge clk) disable iff (!rst_n)
      (match_now && !$past(match_now)) |=> status);

   // R6: status only rises on the start of a match
   a_r6_no_set_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!status && !(match_now && !$past(match_now))) |=> !status);

   // R7: clear write drops the status when no new match starts
   a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && !(match_now && !$past(match_now))) |=> !status);

   // R9: set wins over clear
   a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && match_now && !$past(match_now)) |=> status);

   // R8: disabling the interrupt silences the output
   a_r8_irq_off_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
      ie_off_w |=> !irq);

endmodule

bind cal_alarm_match cam_alarm_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .IE_POS(IE_POS),
   .ST_POS(ST_POS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .field_en (field_en),
   .match_now(match_now),
   .status   (alarm_status),
   .irq      (alarm_irq)
);

// File: tb/tb_cal_alarm_match.sv
`timescale 1ns/1ps
module tb_cal_alarm_match;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [15:0] wr_data;
   logic [7:0]  cal_v [7];
   logic        alarm_status;
   logic        alarm_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cal_alarm_match dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .cal_sec     (cal_v[0][6:0]),
      .cal_min     (cal_v[1][6:0]),
      .cal_hour    (cal_v[2][5:0]),
      .cal_wday    (cal_v[3][2:0]),
      .cal_day     (cal_v[4][5:0]),
      .cal_month   (cal_v[5][4:0]),
      .cal_year    (cal_v[6][7:0]),
      .alarm_status(alarm_status),
      .alarm_irq   (alarm_irq)
   );

   function automatic logic [7:0] base_val(input int i);
      case (i)
         0: return 8'h45;
         1: return 8'h30;
         2: return 8'h12;
         3: return 8'h03;
         4: return 8'h15;
         5: return 8'h06;
         default: return 8'h24;
      endcase
   endfunction

   task automatic chk(input string rq, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_cal(input bit alt);
      for (int i = 0; i < 7; i++) cal_v[i] = alt ? (base_val(i) ^ 8'h01) : base_val(i);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      for (int i = 0; i < 7; i++) cal_v[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 status", alarm_status, 1'b0);
      chk("R10 irq", alarm_irq, 1'b0);

      set_cal(1'b0);
      wr(4'd8, 16'h0001);

      // R1: staged, uncommitted alarm matching the calendar (weekday left out)
      for (int i = 0; i < 7; i++) wr(4'(i), {(i != 3), 7'b0, base_val(i)});
      idle(4);
      chk("R1 staged only", alarm_status, 1'b0);

      // R2: commit register without bit 15 does nothing
      wr(4'd7, 16'h0001);
      idle(2);
      chk("R2 commit bit clear", alarm_status, 1'b0);
      wr(4'd7, 16'h8000);
      // R5: not yet set in the cycle the match starts
      chk("R5 first cycle", alarm_status, 1'b0);
      @(negedge clk);
      chk("R5 set", alarm_status, 1'b1);
      chk("R8 irq with enable", alarm_irq, 1'b1);

      // R5: sticky after the match ends
      idle(3);
      cal_v[0] = 8'h46;
      idle(2);
      chk("R5 sticky", alarm_status, 1'b1);

      // R7: write with bit 0 clear leaves status, bit 0 set clears
      wr(4'd9, 16'h0000);
      chk("R7 zero write", alarm_status, 1'b1);
      wr(4'd9, 16'h0001);
      chk("R7 clear", alarm_status, 1'b0);

      // R6: re-arm only after the condition goes false
      cal_v[0] = 8'h45;
      @(negedge clk);
      chk("R6 new match", alarm_status, 1'b1);
      wr(4'd9, 16'h0001);
      idle(3);
      chk("R6 held match no reset", alarm_status, 1'b0);
      cal_v[0] = 8'h46;
      @(negedge clk);
      cal_v[0] = 8'h45;
      @(negedge clk);
      chk("R6 re-fire", alarm_status, 1'b1);

      // R8: interrupt gating by bit 0 only
      wr(4'd8, 16'h0000);
      chk("R8 irq disabled", alarm_irq, 1'b0);
      chk("R8 status kept", alarm_status, 1'b1);
      wr(4'd8, 16'h0001);
      chk("R8 irq enabled", alarm_irq, 1'b1);
      wr(4'd8, 16'h0002);
      chk("R8 other bit", alarm_irq, 1'b0);
      wr(4'd8, 16'h0001);

      // R9: set and clear in the same cycle
      cal_v[0] = 8'h46;
      idle(2);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h0001; cal_v[0] = 8'h45;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R9 set wins", alarm_status, 1'b1);

      // R11: bits above the seconds width are dropped
      set_cal(1'b1);
      wr(4'd0, 16'h8000 | 16'h0080 | 16'h0045);
      for (int i = 1; i < 7; i++) wr(4'(i), 16'h0000);
      wr(4'd7, 16'h8000);
      wr(4'd9, 16'h0001);
      chk("R11 cleared", alarm_status, 1'b0);
      set_cal(1'b0);
      @(negedge clk);
      chk("R11 masked compare", alarm_status, 1'b1);

      // R3/R4: sweep every enable mask against one mismatching field
      for (int m = 0; m < 128; m++) begin
         for (int f = 0; f < 7; f++) begin
            logic ex;
            set_cal(1'b1);
            for (int i = 0; i < 7; i++)
               wr(4'(i), {m[i], 7'b0, (i == f) ? (base_val(i) ^ 8'h02) : base_val(i)});
            wr(4'd7, 16'h8000);
            wr(4'd9, 16'h0001);
            chk("R7 sweep clear", alarm_status, 1'b0);
            set_cal(1'b0);
            @(negedge clk);
            ex = (m != 0) && !m[f];
            if (m == 0) begin
               chk("R4 none enabled", alarm_status, 1'b0);
            end else begin
               chk("R3 masked match", alarm_status, ex);
               chk("R3 masked irq", alarm_irq, ex);
            end
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule